// File: doc/BRIEF.md
# Scoreboard Result Commit and Forwarding Controller

This block is the write-back controller of a scoreboarded out-of-order core that does not rename registers. Every function unit owns one result latch. For each unit the controller records whether it is occupied, the architectural register it will write, up to two source registers it still has to read, the shadows it sits under, and whether its result has arrived. Program order is the order of issue, kept as an age matrix.

Three streams cross the boundary, each a valid/ready pair. A transfer happens in a cycle where both are high, and each ready is computed without looking at its own valid. Issue (`iss_*`) is accepted when the named unit is idle. Results (`res_*`) are accepted when the named unit is occupied and has not yet received one. Operand reads (`rq_*`) are accepted when the source is still pending and its value can be supplied in that cycle; otherwise the requester holds valid and retries. The register-file write port and the shadow set, clear and cancel vectors are plain control pins.

A finished result stays in its latch, where younger consumers can read it. It is written to the register file only when no shadow covers it, no older instruction still has to read the old value of its register, and no older instruction writes the same register. Cancelling a shadow frees every unit under it with no write.

Top module: `sb_commit_fwd`

## Requirements
- R1: `iss_ready` is high exactly when unit `iss_unit` is idle; an accepted issue makes that unit occupied with no result, and that unit is the youngest instruction.
- R2: `res_ready` is high exactly when unit `res_unit` is occupied and holds no result; an accepted result is stored in that unit's latch.
- R3: A latched result is written only when its unit has no shadow bit set and no older occupied unit has a pending source read of the same register (write-after-read wait).
- R4: At most one register-file write happens per cycle; of the units allowed to write, the oldest is chosen, and a unit never writes while an older occupied unit targets the same register. A unit is freed in the cycle after its write.
- R5: For a read of source `rq_sel` (0 = first source, 1 = second) of unit `rq_unit`, the producer is the youngest occupied writing unit older than the requester whose destination equals that source register. With a producer holding its result, the data comes from its latch and `rq_fwd` is 1; with a producer still waiting for its result, `rq_ready` is 0; with no producer, `rf_rd_addr` carries the source register, the data is `rf_rd_data` and `rq_fwd` is 0.
- R6: A read is accepted only for an occupied unit whose selected source is still pending; an accepted read clears that pending flag.
- R7: Bit i of the shadow vectors stands for shadow i. `sh_set` makes a shadow live, `sh_clr` retires it and removes it from every unit; an issue keeps only those bits of `iss_shadow` that are live or being set in that cycle and are not being cleared or cancelled in that cycle.
- R8: `sh_cancel` retires the shadows it names and frees every occupied unit under any of them in the same cycle, with no register-file write, even if a result for that unit arrives in that cycle.
- R9: A unit issued with `iss_wen` low is freed, without any write, in the cycle after it holds a result and no shadow.
- R10: After reset all units are idle, no shadow is live, `rf_we` is 0 and `iss_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Named unit is idle |
| iss_unit | input | UW | Unit receiving the instruction |
| iss_wen | input | 1 | Instruction writes a register |
| iss_dst | input | RW | Destination register |
| iss_src0_en | input | 1 | First source must be read |
| iss_src0 | input | RW | First source register |
| iss_src1_en | input | 1 | Second source must be read |
| iss_src1 | input | RW | Second source register |
| iss_shadow | input | NSH | Shadows the instruction sits under |
| res_valid | input | 1 | Result delivery |
| res_ready | output | 1 | Named unit awaits a result |
| res_unit | input | UW | Unit producing the result |
| res_data | input | DW | Result value |
| rq_valid | input | 1 | Operand read request |
| rq_ready | output | 1 | Operand can be supplied now |
| rq_unit | input | UW | Requesting unit |
| rq_sel | input | 1 | Source slot (0 or 1) |
| rq_data | output | DW | Operand value |
| rq_fwd | output | 1 | Operand came from a result latch |
| rf_rd_addr | output | RW | Register-file read address |
| rf_rd_data | input | DW | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | RW | Register-file write address |
| rf_wdata | output | DW | Register-file write data |
| sh_set | input | NSH | Shadows becoming live |
| sh_clr | input | NSH | Shadows resolved |
| sh_cancel | input | NSH | Shadows cancelled |

## Verification
The two functions that meet in one cycle are forwarding and commit: a consumer reads a producer's latch in the same cycle that the producer is chosen to write, and a cancel lands in the same cycle as a result for a unit under it. The bench provokes both with directed sequences and with a long run of mixed random issue, result, read and shadow traffic on a small register set, so hazards on the same register are frequent. A behavioural model that tracks instructions by issue number is compared on every cycle against every ready, the write port and the forwarded operand, so a read that returns stale data, or a write that slips ahead of a waiting read, shows up in the cycle it happens.

// File: rtl/sb_commit_fwd_pkg.sv
package sb_commit_fwd_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_LATCH   = 2'd1,
    SRC_STALL   = 2'd2
  } opnd_path_e;
endpackage

// File: rtl/sb_slot_table.sv
module sb_slot_table #(
  parameter int NU = 4,
  parameter int NREG = 8,
  parameter int DW = 16,
  parameter int NSH = 4,
  localparam int UW = (NU > 1) ? $clog2(NU) : 1,
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_do,
  input  logic [UW-1:0]             iss_unit,
  input  logic                      iss_wen,
  input  logic [RW-1:0]             iss_dst,
  input  logic [1:0]                iss_src_en,
  input  logic [1:0][RW-1:0]        iss_src,
  input  logic [NSH-1:0]            iss_shadow,
  input  logic                      res_do,
  input  logic [UW-1:0]             res_unit,
  input  logic [DW-1:0]             res_data,
  input  logic                      rd_do,
  input  logic [UW-1:0]             rd_unit,
  input  logic                      rd_sel,
  input  logic [NU-1:0]             retire,
  input  logic [NU-1:0]             commit,
  input  logic [NSH-1:0]            sh_set,
  input  logic [NSH-1:0]            sh_clr,
  input  logic [NSH-1:0]            sh_cancel,
  output logic [NU-1:0]             busy,
  output logic [NU-1:0]             avail,
  output logic [NU-1:0]             wen,
  output logic [NU-1:0][RW-1:0]     dst,
  output logic [NU-1:0][1:0][RW-1:0] src,
  output logic [NU-1:0][1:0]        pend,
  output logic [NU-1:0]             shm_zero,
  output logic [NU-1:0][DW-1:0]     data,
  output logic [NU-1:0][NU-1:0]     older
);
  logic [NSH-1:0]          live_q;
  logic [NU-1:0][NSH-1:0]  shm_q;
  logic [NU-1:0]           cancel_hit;
  logic [NSH-1:0]          kill;
  logic [NSH-1:0]          live_now;

  assign kill     = sh_clr | sh_cancel;
  assign live_now = live_q | sh_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else        live_q <= live_now & ~kill;
  end

  for (genvar u = 0; u < NU; u++) begin : g_slot
    logic hit_iss;
    assign hit_iss       = iss_do && (iss_unit == UW'(u));
    assign cancel_hit[u] = busy[u] && |(shm_q[u] & sh_cancel);
    assign shm_zero[u]   = (shm_q[u] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy[u]  <= 1'b0;
        avail[u] <= 1'b0;
        wen[u]   <= 1'b0;
        dst[u]   <= '0;
        src[u]   <= '0;
        pend[u]  <= '0;
        shm_q[u] <= '0;
        data[u]  <= '0;
        older[u] <= '0;
      end else if (hit_iss) begin
        busy[u]  <= 1'b1;
        avail[u] <= 1'b0;
        wen[u]   <= iss_wen;
        dst[u]   <= iss_dst;
        src[u]   <= iss_src;
        pend[u]  <= iss_src_en;
        shm_q[u] <= iss_shadow & live_now & ~kill;
        older[u] <= busy;
      end else begin
        if (retire[u] || cancel_hit[u]) busy[u] <= 1'b0;
        if (res_do && res_unit == UW'(u)) begin
          avail[u] <= 1'b1;
          data[u]  <= res_data;
        end
        if (rd_do && rd_unit == UW'(u)) pend[u][rd_sel] <= 1'b0;
        shm_q[u] <= shm_q[u] & ~kill;
        if (iss_do) older[u][iss_unit] <= 1'b0;
      end
    end

    AST_CANCEL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_hit[u] |=> !busy[u]) else $error("cancelled unit still occupied"); // R8
  end

  AST_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_do |-> !busy[iss_unit]) else $error("issue to occupied unit"); // R1
  AST_COMMIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (commit & ~(busy & avail & shm_zero)) == '0) else $error("commit of unready unit"); // R3
  AST_NO_WRITE_CANCELLED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit & cancel_hit) == '0) else $error("commit of cancelled unit"); // R8
endmodule

// File: rtl/sb_commit_pick.sv
module sb_commit_pick #(
  parameter int NU = 4,
  parameter int NREG = 8,
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NU-1:0]              busy,
  input  logic [NU-1:0]              avail,
  input  logic [NU-1:0]              wen,
  input  logic [NU-1:0][RW-1:0]      dst,
  input  logic [NU-1:0][1:0][RW-1:0] src,
  input  logic [NU-1:0][1:0]         pend,
  input  logic [NU-1:0]              shm_zero,
  input  logic [NU-1:0][NU-1:0]      older,
  output logic [NU-1:0]              grant,
  output logic [NU-1:0]              done_nw
);
  logic [NU-1:0] elig;

  always_comb begin
    for (int p = 0; p < NU; p++) begin
      logic war_h;
      logic waw_h;
      war_h = 1'b0;
      waw_h = 1'b0;
      for (int q = 0; q < NU; q++) begin
        if (older[p][q] && busy[q]) begin
          if ((pend[q][0] && src[q][0] == dst[p]) || (pend[q][1] && src[q][1] == dst[p]))
            war_h = 1'b1;
          if (wen[q] && dst[q] == dst[p]) waw_h = 1'b1;
        end
      end
      elig[p]    = busy[p] && avail[p] && wen[p] && shm_zero[p] && !war_h && !waw_h;
      done_nw[p] = busy[p] && avail[p] && !wen[p] && shm_zero[p];
    end
    for (int p = 0; p < NU; p++) begin
      grant[p] = elig[p];
      for (int q = 0; q < NU; q++)
        if (elig[q] && older[p][q]) grant[p] = 1'b0;
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) else $error("more than one write granted"); // R4
endmodule

// File: rtl/sb_fwd_pick.sv
module sb_fwd_pick
  import sb_commit_fwd_pkg::*;
#(
  parameter int NU = 4,
  parameter int NREG = 8,
  localparam int UW = (NU > 1) ? $clog2(NU) : 1,
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rq_valid,
  input  logic [UW-1:0]              rq_unit,
  input  logic                       rq_sel,
  input  logic [NU-1:0]              busy,
  input  logic [NU-1:0]              avail,
  input  logic [NU-1:0]              wen,
  input  logic [NU-1:0][RW-1:0]      dst,
  input  logic [NU-1:0][1:0][RW-1:0] src,
  input  logic [NU-1:0][1:0]         pend,
  input  logic [NU-1:0][NU-1:0]      older,
  output logic                       rq_ready,
  output logic                       rq_fwd,
  output logic [UW-1:0]              prod,
  output logic [RW-1:0]              rd_reg
);
  logic [NU-1:0] cand;
  logic [NU-1:0] pick;
  opnd_path_e    path;

  assign rd_reg = src[rq_unit][rq_sel];

  always_comb begin
    for (int p = 0; p < NU; p++)
      cand[p] = busy[p] && wen[p] && dst[p] == rd_reg && older[rq_unit][p];
    prod = '0;
    for (int p = 0; p < NU; p++) begin
      pick[p] = cand[p];
      for (int q = 0; q < NU; q++)
        if (cand[q] && older[q][p]) pick[p] = 1'b0;
      if (pick[p]) prod = UW'(p);
    end
    if (pick == '0)        path = SRC_REGFILE;
    else if (avail[prod])  path = SRC_LATCH;
    else                   path = SRC_STALL;
  end

  assign rq_ready = busy[rq_unit] && pend[rq_unit][rq_sel] && (path != SRC_STALL);
  assign rq_fwd   = (path == SRC_LATCH);

  AST_READ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !(busy[rq_unit] && pend[rq_unit][rq_sel])) |-> !rq_ready)
    else $error("read accepted for a source that is not pending"); // R6
endmodule

// File: rtl/sb_commit_fwd.sv
module sb_commit_fwd #(
  parameter int NU = 4,
  parameter int NREG = 8,
  parameter int DW = 16,
  parameter int NSH = 4,
  localparam int UW = (NU > 1) ? $clog2(NU) : 1,
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_valid,
  output logic           iss_ready,
  input  logic [UW-1:0]  iss_unit,
  input  logic           iss_wen,
  input  logic [RW-1:0]  iss_dst,
  input  logic           iss_src0_en,
  input  logic [RW-1:0]  iss_src0,
  input  logic           iss_src1_en,
  input  logic [RW-1:0]  iss_src1,
  input  logic [NSH-1:0] iss_shadow,
  input  logic           res_valid,
  output logic           res_ready,
  input  logic [UW-1:0]  res_unit,
  input  logic [DW-1:0]  res_data,
  input  logic           rq_valid,
  output logic           rq_ready,
  input  logic [UW-1:0]  rq_unit,
  input  logic           rq_sel,
  output logic [DW-1:0]  rq_data,
  output logic           rq_fwd,
  output logic [RW-1:0]  rf_rd_addr,
  input  logic [DW-1:0]  rf_rd_data,
  output logic           rf_we,
  output logic [RW-1:0]  rf_waddr,
  output logic [DW-1:0]  rf_wdata,
  input  logic [NSH-1:0] sh_set,
  input  logic [NSH-1:0] sh_clr,
  input  logic [NSH-1:0] sh_cancel
);
  logic [NU-1:0]              busy, avail, wen, shm_zero, grant, done_nw;
  logic [NU-1:0][RW-1:0]      dst;
  logic [NU-1:0][1:0][RW-1:0] src;
  logic [NU-1:0][1:0]         pend;
  logic [NU-1:0][DW-1:0]      data;
  logic [NU-1:0][NU-1:0]      older;
  logic [UW-1:0]              prod;
  logic                       iss_do, res_do, rd_do;

  assign iss_ready = !busy[iss_unit];
  assign res_ready = busy[res_unit] && !avail[res_unit];
  assign iss_do    = iss_valid && iss_ready;
  assign res_do    = res_valid && res_ready;
  assign rd_do     = rq_valid && rq_ready;

  sb_slot_table #(.NU(NU), .NREG(NREG), .DW(DW), .NSH(NSH)) u_table (
    .clk(clk), .rst_n(rst_n),
    .iss_do(iss_do), .iss_unit(iss_unit), .iss_wen(iss_wen), .iss_dst(iss_dst),
    .iss_src_en({iss_src1_en, iss_src0_en}), .iss_src({iss_src1, iss_src0}),
    .iss_shadow(iss_shadow),
    .res_do(res_do), .res_unit(res_unit), .res_data(res_data),
    .rd_do(rd_do), .rd_unit(rq_unit), .rd_sel(rq_sel),
    .retire(grant | done_nw), .commit(grant),
    .sh_set(sh_set), .sh_clr(sh_clr), .sh_cancel(sh_cancel),
    .busy(busy), .avail(avail), .wen(wen), .dst(dst), .src(src), .pend(pend),
    .shm_zero(shm_zero), .data(data), .older(older)
  );

  sb_commit_pick #(.NU(NU), .NREG(NREG)) u_commit (
    .clk(clk), .rst_n(rst_n),
    .busy(busy), .avail(avail), .wen(wen), .dst(dst), .src(src), .pend(pend),
    .shm_zero(shm_zero), .older(older), .grant(grant), .done_nw(done_nw)
  );

  sb_fwd_pick #(.NU(NU), .NREG(NREG)) u_fwd (
    .clk(clk), .rst_n(rst_n),
    .rq_valid(rq_valid), .rq_unit(rq_unit), .rq_sel(rq_sel),
    .busy(busy), .avail(avail), .wen(wen), .dst(dst), .src(src), .pend(pend),
    .older(older), .rq_ready(rq_ready), .rq_fwd(rq_fwd), .prod(prod), .rd_reg(rf_rd_addr)
  );

  assign rq_data = rq_fwd ? data[prod] : rf_rd_data;

  always_comb begin
    rf_waddr = '0;
    rf_wdata = '0;
    for (int p = 0; p < NU; p++) begin
      rf_waddr |= dst[p]  & {RW{grant[p]}};
      rf_wdata |= data[p] & {DW{grant[p]}};
    end
  end
  assign rf_we = |grant;

  AST_NO_WRITE_IN_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rf_we) else $error("write right after reset"); // R10
endmodule

// File: tb/sb_commit_fwd_tb.sv
`timescale 1ns/1ps
module sb_commit_fwd_tb;
  localparam int NU = 4, NREG = 8, DW = 16, NSH = 4;
  localparam int UW = 2, RW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid, iss_ready, iss_wen, iss_src0_en, iss_src1_en;
  logic [UW-1:0] iss_unit, res_unit, rq_unit;
  logic [RW-1:0] iss_dst, iss_src0, iss_src1, rf_rd_addr, rf_waddr;
  logic [NSH-1:0] iss_shadow, sh_set, sh_clr, sh_cancel;
  logic res_valid, res_ready, rq_valid, rq_ready, rq_sel, rq_fwd, rf_we;
  logic [DW-1:0] res_data, rq_data, rf_rd_data, rf_wdata;
  logic [DW-1:0] regs [NREG];

  always #2.5 clk = ~clk;

  sb_commit_fwd #(.NU(NU), .NREG(NREG), .DW(DW), .NSH(NSH)) u_dut (.*);

  assign rf_rd_data = regs[rf_rd_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= DW'(16'h0100 + i);
    end else if (rf_we) regs[rf_waddr] <= rf_wdata;
  end

  // reference model, instructions tracked by issue number
  bit m_busy [NU], m_avail [NU], m_wen [NU];
  int m_seq [NU], m_dst [NU], m_src [NU][2];
  bit m_pend [NU][2];
  bit [NSH-1:0] m_shm [NU], m_act;
  logic [DW-1:0] m_data [NU];
  int seqctr = 0, checks = 0, fails = 0, cyc = 0;
  string cur_tag = "";
  bit finished = 0;

  task automatic chk(string dflt, string what, logic [31:0] act, logic [31:0] exp);
    string t;
    t = (cur_tag == "") ? dflt : cur_tag;
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", t, what, act, exp, cyc);
    end
  endtask

  task automatic idle_in();
    iss_valid = 0; iss_unit = 0; iss_wen = 0; iss_dst = 0; iss_src0_en = 0; iss_src0 = 0;
    iss_src1_en = 0; iss_src1 = 0; iss_shadow = 0; res_valid = 0; res_unit = 0; res_data = 0;
    rq_valid = 0; rq_unit = 0; rq_sel = 0; sh_set = 0; sh_clr = 0; sh_cancel = 0;
  endtask

  task automatic step();
    int gu, pr, c, r;
    bit ok, e_iss, e_res, e_rq;
    bit fin [NU];
    logic [DW-1:0] e_data;
    bit [NSH-1:0] kill, live;
    #1;
    e_iss = !m_busy[iss_unit];
    e_res = m_busy[res_unit] && !m_avail[res_unit];
    gu = -1;
    for (int p = 0; p < NU; p++) begin
      ok = m_busy[p] && m_avail[p] && m_wen[p] && m_shm[p] == 0;
      for (int q = 0; q < NU; q++)
        if (m_busy[q] && m_seq[q] < m_seq[p]) begin
          if ((m_pend[q][0] && m_src[q][0] == m_dst[p]) || (m_pend[q][1] && m_src[q][1] == m_dst[p])) ok = 0;
          if (m_wen[q] && m_dst[q] == m_dst[p]) ok = 0;
        end
      if (ok && (gu < 0 || m_seq[p] < m_seq[gu])) gu = p;
    end
    c = int'(rq_unit); r = m_src[c][rq_sel]; pr = -1;
    for (int p = 0; p < NU; p++)
      if (p != c && m_busy[p] && m_wen[p] && m_dst[p] == r && m_seq[p] < m_seq[c] &&
          (pr < 0 || m_seq[p] > m_seq[pr])) pr = p;
    e_rq = m_busy[c] && m_pend[c][rq_sel] && (pr < 0 || m_avail[pr]);
    e_data = (pr < 0) ? regs[r] : m_data[pr];
    chk("R1", "iss_ready", 32'(iss_ready), 32'(e_iss));
    chk("R2", "res_ready", 32'(res_ready), 32'(e_res));
    chk("R3", "rf_we", 32'(rf_we), 32'(gu >= 0));
    if (gu >= 0) begin
      chk("R4", "rf_waddr", 32'(rf_waddr), 32'(m_dst[gu]));
      chk("R4", "rf_wdata", 32'(rf_wdata), 32'(m_data[gu]));
    end
    if (rq_valid) begin
      chk("R6", "rq_ready", 32'(rq_ready), 32'(e_rq));
      if (e_rq) begin
        chk("R5", "rq_fwd", 32'(rq_fwd), 32'(pr >= 0));
        chk("R5", "rq_data", 32'(rq_data), 32'(e_data));
      end
    end
    kill = sh_clr | sh_cancel;
    live = m_act | sh_set;
    for (int u = 0; u < NU; u++)
      fin[u] = m_busy[u] && (u == gu || (m_avail[u] && !m_wen[u] && m_shm[u] == 0) ||
                             (m_shm[u] & sh_cancel) != 0);
    if (rq_valid && e_rq) m_pend[c][rq_sel] = 0;
    if (res_valid && e_res) begin m_avail[res_unit] = 1; m_data[res_unit] = res_data; end
    for (int u = 0; u < NU; u++) begin
      m_shm[u] &= ~kill;
      if (fin[u]) m_busy[u] = 0;
    end
    if (iss_valid && e_iss) begin
      m_busy[iss_unit] = 1; m_avail[iss_unit] = 0; m_wen[iss_unit] = iss_wen;
      m_dst[iss_unit] = int'(iss_dst);
      m_src[iss_unit][0] = int'(iss_src0); m_src[iss_unit][1] = int'(iss_src1);
      m_pend[iss_unit][0] = iss_src0_en; m_pend[iss_unit][1] = iss_src1_en;
      m_shm[iss_unit] = iss_shadow & live & ~kill;
      m_seq[iss_unit] = seqctr++;
    end
    m_act = live & ~kill;
    @(negedge clk);
    cyc++;
    idle_in();
  endtask

  task automatic iss(int u, bit w, int d, bit e0, int s0, bit e1, int s1, int sh);
    iss_valid = 1; iss_unit = UW'(u); iss_wen = w; iss_dst = RW'(d);
    iss_src0_en = e0; iss_src0 = RW'(s0); iss_src1_en = e1; iss_src1 = RW'(s1);
    iss_shadow = NSH'(sh);
  endtask
  task automatic res(int u, int d);
    res_valid = 1; res_unit = UW'(u); res_data = DW'(d);
  endtask
  task automatic rq(int u, bit s);
    rq_valid = 1; rq_unit = UW'(u); rq_sel = s;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    for (int u = 0; u < NU; u++) begin
      m_busy[u] = 0; m_avail[u] = 0; m_wen[u] = 0; m_seq[u] = 0; m_dst[u] = 0;
      m_src[u][0] = 0; m_src[u][1] = 0; m_pend[u][0] = 0; m_pend[u][1] = 0;
      m_shm[u] = 0; m_data[u] = 0;
    end
    m_act = 0;
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: state right after reset
    cur_tag = "R10"; step();
    // R1: issue accepted only on an idle unit
    cur_tag = "R1"; iss(0, 1, 2, 0, 0, 0, 0, 0); step();
    iss(0, 1, 5, 0, 0, 0, 0, 0); step();
    // R5: read stalls on a pending producer, then forwards from its latch
    cur_tag = "R5"; iss(1, 1, 3, 1, 2, 0, 0, 0); step();
    rq(1, 0); step();
    res(0, 16'hAAAA); step();
    rq(1, 0); step();
    // R6: second read of the same source is refused
    cur_tag = "R6"; rq(1, 0); step();
    res(1, 16'h1234); idle(3);
    // R3: write-after-read wait on r5
    cur_tag = "R3"; iss(2, 1, 6, 1, 5, 0, 0, 0); step();
    iss(3, 1, 5, 0, 0, 0, 0, 0); step();
    res(3, 16'h5555); idle(3);
    rq(2, 0); step();
    idle(2); res(2, 16'h6666); idle(2);
    // R7: shadow hold and release, issue mask of a dead shadow dropped
    cur_tag = "R7"; sh_set = 4'b0001; step();
    iss(0, 1, 1, 0, 0, 0, 0, 4'b1001); step();
    res(0, 16'h7777); idle(3);
    sh_clr = 4'b0001; step(); idle(2);
    // R8: cancel frees without a write, result in the same cycle discarded
    cur_tag = "R8"; sh_set = 4'b0010; step();
    iss(1, 1, 4, 0, 0, 0, 0, 4'b0010); step();
    iss(2, 1, 4, 0, 0, 0, 0, 4'b0010); step();
    res(1, 16'h8888); step();
    res(2, 16'h9999); sh_cancel = 4'b0010; step();
    idle(2); iss(1, 1, 0, 0, 0, 0, 0, 0); step(); res(1, 16'h0A0A); idle(2);
    // R9: no-destination unit frees without a write
    cur_tag = "R9"; iss(2, 0, 0, 0, 0, 0, 0, 0); step();
    res(2, 16'hBBBB); idle(2);
    iss(2, 0, 0, 0, 0, 0, 0, 0); step(); idle(1);
    res(2, 16'h0); idle(2);
    // R4: same-register writes stay in program order
    cur_tag = "R4"; sh_set = 4'b0100; step();
    iss(0, 1, 7, 0, 0, 0, 0, 4'b0100); step();
    iss(1, 1, 7, 0, 0, 0, 0, 0); step();
    iss(2, 1, 6, 0, 0, 0, 0, 0); res(1, 16'hC1C1); step();
    res(0, 16'hC0C0); step();
    res(2, 16'hC2C2); idle(2);
    sh_clr = 4'b0100; step(); idle(3);
    // mixed random traffic, per-output requirement tags
    cur_tag = "";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99) < 35)
        iss(int'($urandom_range(NU - 1)), $urandom_range(9) < 8, int'($urandom_range(3)),
            1'($urandom), int'($urandom_range(3)), 1'($urandom), int'($urandom_range(3)),
            ($urandom_range(3) == 0) ? int'($urandom_range(15)) : 0);
      if ($urandom_range(99) < 45) res(int'($urandom_range(NU - 1)), int'($urandom_range(16'hFFFF)));
      if ($urandom_range(99) < 55) rq(int'($urandom_range(NU - 1)), 1'($urandom));
      if ($urandom_range(99) < 8) sh_set = NSH'(1 << $urandom_range(NSH - 1));
      if ($urandom_range(99) < 7) sh_clr = NSH'(1 << $urandom_range(NSH - 1));
      if ($urandom_range(99) < 2) sh_cancel = NSH'(1 << $urandom_range(NSH - 1));
      step();
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule